// File: doc/BRIEF.md
# Grouped Down-Counting Timer Bank

This block packs two or three independent down-counting timer channels behind one 48-byte register window. A shared run register starts and stops each channel through its own bit. An optional one-bit output-control register sits at the bottom of the window. Each channel has a reload value, a live count, a control word with a prescale select, an interrupt enable and a sticky underflow flag. The third channel, when it is built, also has a plain 32-bit capture register.

A running channel steps its count down once per prescaled tick. When a tick finds the count at zero, the count is refilled from the reload value and the underflow flag is set. The flag drives a level interrupt while its enable bit is set. Software clears the flag by writing its control word with the flag bit at zero. Reads are combinational from the address. Writes take effect at the clock edge where `wr_en_i` is high.

Top module: `tmr_bank`

## Requirements
- R1: Word offset 0x00 holds a one-bit output-control value, built only when `HAS_OUTCTL` is 1. A write keeps data bit 0, and a read returns it in bit 0 with zeros above. When the register is absent, reads return 0.
- R2: Offset 0x04 is the run register. It stores all 32 written bits and reads them back unchanged. Bit 0 runs channel 0, bit 1 runs channel 1 and bit 2 runs channel 2. Bit 2 does nothing when the third channel is not built.
- R3: A stopped channel holds its count. Writing a run bit with the value it already has changes neither the count nor the prescaler phase.
- R4: On each tick a running channel lowers its count by one. A tick that finds the count at 0 loads the reload value and sets the underflow flag (control bit 8).
- R5: Control bits [2:0] select the tick rate. Values 0 to 4 give one tick every 4, 16, 64, 256 and 1024 clocks. The first tick comes that many edges after the edge that starts the channel or writes its control word. Value 5 never ticks. Values 6 and 7 tick on each clock with `ext_tick_i` high when `HAS_EXT_CLK` is 1, and never tick otherwise.
- R6: Control bits [7:0] are stored, and bit 5 is the interrupt enable. A control write with bit 8 at 0 clears the flag, and a write with bit 8 at 1 leaves it alone. An underflow in the same cycle wins over the clear. Reads return bits [7:0], the flag in bit 8 and zeros above.
- R7: `irq_o[i]` is high exactly while channel i has its flag set and its enable set.
- R8: The channel registers are at these offsets. Channel 0: reload 0x08, count 0x0C, control 0x10. Channel 1: reload 0x14, count 0x18, control 0x1C. Channel 2: reload 0x20, count 0x24, control 0x28, capture 0x2C.
- R9: Only channel 2 has the capture register. It is a 32-bit read/write value that resets to 0.
- R10: After reset, reload and count are all ones, control and flag are 0, and the run and output-control registers are 0.
- R11: These reads return 0 and writes to them change nothing: offsets 0x30 to 0x3F, addresses whose low two bits are not zero, and the channel 2 words when that channel is not built.
- R12: A count write in the same cycle as a tick wins, so the written value is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 6 | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| ext_tick_i | input | 1 | Shared external count enable |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 3 | Per-channel interrupt level; bit 2 is 0 when channel 2 is absent |

## Verification
The bench builds two copies side by side. One has the third channel, the output-control register and the external tick enabled. The other has all three options turned off. The full copy gives access to the capture register and to rate selects 6 and 7 counting on `ext_tick_i`. The reduced copy is driven with the same external pulses and the same writes to the upper words, so the bench can show that those words read back as zero, that run bit 2 is inert and that the external selects stay still.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int MAX_CH  = 3;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int CTL_W   = 8;
  localparam int SEL_W   = 3;
  localparam int RSEL_W  = 2;
  localparam int PRE_W   = 10;
  localparam int IE_BIT  = 5;
  localparam int FLAG_BIT = 8;
  localparam int MAX_DIV_SEL = 4;

  // low-order ones mask: divide by 2^(2*sel+2)
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int k = 0; k < PRE_W; k++)
      if (k < 2 * int'(sel) + 2) m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_bank_pkg::*;
#(
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_outctl_o,
  output logic              hit_start_o,
  output logic [MAX_CH-1:0] ch_sel_o,
  output logic [RSEL_W-1:0] rsel_o
);
  logic [3:0] word;
  logic       aligned;

  assign word    = addr_i[5:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    hit_outctl_o = 1'b0;
    hit_start_o  = 1'b0;
    ch_sel_o     = '0;
    rsel_o       = '0;
    if (aligned) begin
      case (word)
        4'd0: hit_outctl_o = HAS_OUTCTL;
        4'd1: hit_start_o  = 1'b1;
        4'd2, 4'd3, 4'd4: begin
          ch_sel_o[0] = 1'b1;
          rsel_o      = word[1:0] - 2'd2;
        end
        4'd5, 4'd6, 4'd7: begin
          ch_sel_o[1] = 1'b1;
          rsel_o      = word[1:0] - 2'd1;
        end
        4'd8, 4'd9, 4'd10, 4'd11: begin
          ch_sel_o[2] = HAS_CH2;
          rsel_o      = word[1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_bank_pkg::*;
#(
  parameter bit HAS_EXT_CLK = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_tick_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             div_ok, div_tick, ext_ok;

  assign mask     = div_mask(sel_i);
  assign div_ok   = (sel_i <= SEL_W'(MAX_DIV_SEL));
  assign div_tick = run_i && div_ok && (pre_q == mask);
  assign ext_ok   = HAS_EXT_CLK && (sel_i[2:1] == 2'b11);
  assign tick_o   = div_tick || (run_i && ext_ok && ext_tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pre_q <= '0;
    else if (!run_i || restart_i || !div_ok) pre_q <= '0;
    else if (div_tick)                       pre_q <= '0;
    else                                     pre_q <= pre_q + 1'b1;
  end

  // R5: divided ticks are never back to back (shortest period is 4)
  a_r5_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_tick |=> !div_tick);
  // R5: phase never passes the selected terminal value
  a_r5_pre_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_ok |-> (pre_q <= mask));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_bank_pkg::*;
#(
  parameter bit HAS_CAP     = 1'b0,
  parameter bit HAS_EXT_CLK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_i,
  input  logic [RSEL_W-1:0] rsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_tick_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] reload_q, cnt_q, cap_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              flag_q;
  logic              wr_reload, wr_cnt, wr_ctl, tick, underflow;

  assign wr_reload = wr_i && (rsel_i == 2'd0);
  assign wr_cnt    = wr_i && (rsel_i == 2'd1);
  assign wr_ctl    = wr_i && (rsel_i == 2'd2);
  assign underflow = tick && (cnt_q == '0);

  tmr_prescaler #(.HAS_EXT_CLK(HAS_EXT_CLK)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .restart_i  (wr_ctl),
    .sel_i      (ctl_q[SEL_W-1:0]),
    .ext_tick_i (ext_tick_i),
    .tick_o     (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '1;
      cnt_q    <= '1;
      ctl_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata_i;
      if (wr_cnt)    cnt_q    <= wdata_i;
      else if (tick) cnt_q    <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      if (wr_ctl)    ctl_q    <= wdata_i[CTL_W-1:0];
      if (underflow)                          flag_q <= 1'b1;
      else if (wr_ctl && !wdata_i[FLAG_BIT])  flag_q <= 1'b0;
    end
  end

  generate
    if (HAS_CAP) begin : g_cap
      logic wr_cap;
      assign wr_cap = wr_i && (rsel_i == 2'd3);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cap_q <= '0;
        else if (wr_cap) cap_q <= wdata_i;
      end
    end else begin : g_nocap
      assign cap_q = '0;
    end
  endgenerate

  always_comb begin
    case (rsel_i)
      2'd0:    rdata_o = reload_q;
      2'd1:    rdata_o = cnt_q;
      2'd2:    rdata_o = {{(DATA_W-FLAG_BIT-1){1'b0}}, flag_q, ctl_q};
      default: rdata_o = cap_q;
    endcase
  end

  assign irq_o = flag_q && ctl_q[IE_BIT];

  // R3: no movement while stopped unless software writes the count
  a_r3_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt) |=> $stable(cnt_q));
  // R4: zero-count tick refills from reload and raises the flag
  a_r4_reload_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow && !wr_cnt) |=> (cnt_q == $past(reload_q)) && flag_q);
  // R6: clear write removes flag when no underflow competes
  a_r6_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && !wdata_i[FLAG_BIT] && !underflow) |=> !flag_q);
  // R12: written count wins over a coincident tick
  a_r12_cnt_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter bit HAS_CH2     = 1'b1,
  parameter bit HAS_OUTCTL  = 1'b1,
  parameter bit HAS_EXT_CLK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_tick_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MAX_CH-1:0] irq_o
);
  localparam int NUM_CH = HAS_CH2 ? 3 : 2;

  logic              hit_outctl, hit_start;
  logic [MAX_CH-1:0] ch_sel;
  logic [RSEL_W-1:0] rsel;
  logic [DATA_W-1:0] start_q;
  logic              outctl_q;
  logic [DATA_W-1:0] ch_rdata [MAX_CH];

  tmr_decode #(.HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr_i       (addr_i),
    .hit_outctl_o (hit_outctl),
    .hit_start_o  (hit_start),
    .ch_sel_o     (ch_sel),
    .rsel_o       (rsel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    start_q <= '0;
    else if (wr_en_i && hit_start)  start_q <= wdata_i;
  end

  generate
    if (HAS_OUTCTL) begin : g_outctl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    outctl_q <= 1'b0;
        else if (wr_en_i && hit_outctl) outctl_q <= wdata_i[0];
      end
      // R1: only data bit 0 is kept
      a_r1_outctl_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && hit_outctl) |=> (outctl_q == $past(wdata_i[0])));
    end else begin : g_no_outctl
      assign outctl_q = 1'b0;
    end

    for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
      if (i < NUM_CH) begin : g_on
        tmr_channel #(.HAS_CAP(i == 2), .HAS_EXT_CLK(HAS_EXT_CLK)) u_ch (
          .clk_i      (clk_i),
          .rst_ni     (rst_ni),
          .run_i      (start_q[i]),
          .wr_i       (wr_en_i && ch_sel[i]),
          .rsel_i     (rsel),
          .wdata_i    (wdata_i),
          .ext_tick_i (ext_tick_i),
          .rdata_o    (ch_rdata[i]),
          .irq_o      (irq_o[i])
        );
      end else begin : g_off
        assign ch_rdata[i] = '0;
        assign irq_o[i]    = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (hit_outctl)     rdata_o = {{(DATA_W-1){1'b0}}, outctl_q};
    else if (hit_start) rdata_o = start_q;
    else begin
      for (int i = 0; i < MAX_CH; i++)
        if (ch_sel[i]) rdata_o = ch_rdata[i];
    end
  end

  // R2: run register keeps the whole written word
  a_r2_start_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_start) |=> (start_q == $past(wdata_i)));
  // R11: unmapped and misaligned addresses read as zero
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i[1:0] != 2'b00) || (addr_i[5:4] == 2'b11)) |-> (rdata_o == '0));
endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_full = 1'b0, wr_min = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ext_tick = 1'b0;
  logic [31:0] rd_full, rd_min;
  logic [2:0]  irq_full, irq_min;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_full), .addr_i(addr), .wdata_i(wdata),
    .ext_tick_i(ext_tick), .rdata_o(rd_full), .irq_o(irq_full));

  tmr_bank #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0), .HAS_EXT_CLK(1'b0)) dut_min_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_min), .addr_i(addr), .wdata_i(wdata),
    .ext_tick_i(ext_tick), .rdata_o(rd_min), .irq_o(irq_min));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // tgt 0: full copy, 1: reduced copy; returns just after the write edge
  task automatic wr(input bit tgt, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (tgt) wr_min = 1'b1; else wr_full = 1'b1;
    @(posedge clk);
    #0.2;
    wr_full = 1'b0; wr_min = 1'b0;
  endtask

  task automatic rd(input bit tgt, input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #0.2;
    d = tgt ? rd_min : rd_full;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #0.2;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 6'h08, v); chk("R10 reload reset", v, 32'hFFFF_FFFF);
    rd(0, 6'h0C, v); chk("R10 count reset", v, 32'hFFFF_FFFF);
    rd(0, 6'h10, v); chk("R10 control reset", v, 32'h0);
    rd(0, 6'h04, v); chk("R10 run reset", v, 32'h0);
    rd(0, 6'h00, v); chk("R10 outctl reset", v, 32'h0);
    rd(0, 6'h2C, v); chk("R9 capture reset", v, 32'h0);
    chk("R10 irq reset", {29'b0, irq_full}, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(0, 6'h08, 32'h11); wr(0, 6'h14, 32'h22); wr(0, 6'h20, 32'h33);
    wr(0, 6'h1C, 32'h07);
    rd(0, 6'h08, v); chk("R8 ch0 reload", v, 32'h11);
    rd(0, 6'h14, v); chk("R8 ch1 reload", v, 32'h22);
    rd(0, 6'h20, v); chk("R8 ch2 reload", v, 32'h33);
    rd(0, 6'h1C, v); chk("R8 ch1 control", v, 32'h07);
    rd(0, 6'h24, v); chk("R8 ch2 count", v, 32'hFFFF_FFFF);
    wr(0, 6'h2C, 32'hA5A5_5A5A);
    rd(0, 6'h2C, v); chk("R9 capture rw", v, 32'hA5A5_5A5A);
    wr(0, 6'h00, 32'hFFFF_FFFE);
    rd(0, 6'h00, v); chk("R1 outctl bit0 low", v, 32'h0);
    wr(0, 6'h00, 32'h0000_00FF);
    rd(0, 6'h00, v); chk("R1 outctl bit0", v, 32'h1);
    wr(0, 6'h30, 32'hDEAD_0001); wr(0, 6'h09, 32'h55);
    rd(0, 6'h30, v); chk("R11 unmapped read", v, 32'h0);
    rd(0, 6'h09, v); chk("R11 misaligned read", v, 32'h0);
    rd(0, 6'h08, v); chk("R11 misaligned write ignored", v, 32'h11);
    wr(0, 6'h04, 32'hABCD_0000);
    rd(0, 6'h04, v); chk("R2 run readback", v, 32'hABCD_0000);
    wr(0, 6'h04, 32'h0);
  endtask

  task automatic t_countdown;
    logic [31:0] v;
    wr(0, 6'h08, 32'd5); wr(0, 6'h0C, 32'd2); wr(0, 6'h10, 32'h20);
    wr(0, 6'h04, 32'h1);
    edges(7);  rd(0, 6'h0C, v); chk("R4 first step", v, 32'd1);
    edges(1);  rd(0, 6'h0C, v); chk("R4 reach zero", v, 32'd0);
    chk("R7 irq low before underflow", {31'b0, irq_full[0]}, 32'h0);
    edges(4);  rd(0, 6'h0C, v); chk("R4 reload", v, 32'd5);
    rd(0, 6'h10, v); chk("R4 flag set", v, 32'h120);
    chk("R7 irq high", {31'b0, irq_full[0]}, 32'h1);
    wr(0, 6'h04, 32'h0);
  endtask

  task automatic t_flag;
    logic [31:0] v;
    wr(0, 6'h10, 32'h100);
    chk("R7 irq masked", {31'b0, irq_full[0]}, 32'h0);
    rd(0, 6'h10, v); chk("R6 flag kept", v, 32'h100);
    wr(0, 6'h10, 32'h120);
    chk("R7 irq unmasked", {31'b0, irq_full[0]}, 32'h1);
    wr(0, 6'h10, 32'h020);
    chk("R6 clear irq", {31'b0, irq_full[0]}, 32'h0);
    rd(0, 6'h10, v); chk("R6 clear read", v, 32'h20);
  endtask

  task automatic t_hold_restart;
    logic [31:0] v;
    wr(0, 6'h18, 32'd50); wr(0, 6'h1C, 32'h0);
    wr(0, 6'h04, 32'h2);
    edges(9);  rd(0, 6'h18, v); chk("R4 ch1 running", v, 32'd48);
    wr(0, 6'h04, 32'h0);
    edges(20); rd(0, 6'h18, v); chk("R3 stopped hold", v, 32'd48);
    wr(0, 6'h04, 32'h0);
    rd(0, 6'h18, v); chk("R3 stop again", v, 32'd48);
    wr(0, 6'h04, 32'h2);
    edges(3);  rd(0, 6'h18, v); chk("R5 restart phase", v, 32'd48);
    edges(1);  rd(0, 6'h18, v); chk("R5 restart first tick", v, 32'd47);
    wr(0, 6'h04, 32'h2);
    edges(2);  rd(0, 6'h18, v); chk("R3 rerun no effect", v, 32'd47);
    edges(1);  rd(0, 6'h18, v); chk("R3 rerun keeps phase", v, 32'd46);
    for (int k = 0; k < 4; k++) begin
      wr(0, 6'h18, 32'd100);
      rd(0, 6'h18, v); chk("R12 write wins", v, 32'd100);
    end
    wr(0, 6'h04, 32'h0);
  endtask

  task automatic t_rates;
    logic [31:0] v;
    wr(0, 6'h10, 32'h01); wr(0, 6'h0C, 32'd3); wr(0, 6'h04, 32'h1);
    edges(15); rd(0, 6'h0C, v); chk("R5 div16 before", v, 32'd3);
    edges(1);  rd(0, 6'h0C, v); chk("R5 div16 tick", v, 32'd2);
    wr(0, 6'h04, 32'h0);
    wr(0, 6'h10, 32'h04); wr(0, 6'h0C, 32'd3); wr(0, 6'h04, 32'h1);
    edges(1023); rd(0, 6'h0C, v); chk("R5 div1024 before", v, 32'd3);
    edges(1);    rd(0, 6'h0C, v); chk("R5 div1024 tick", v, 32'd2);
    wr(0, 6'h04, 32'h0);
    wr(0, 6'h10, 32'h05); wr(0, 6'h0C, 32'd9); wr(0, 6'h04, 32'h1);
    edges(40); rd(0, 6'h0C, v); chk("R5 select 5 idle", v, 32'd9);
    wr(0, 6'h04, 32'h0);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    wr(0, 6'h10, 32'h06); wr(0, 6'h0C, 32'd10); wr(0, 6'h04, 32'h1);
    wr(1, 6'h10, 32'h06); wr(1, 6'h0C, 32'd10); wr(1, 6'h04, 32'h1);
    edges(10); rd(0, 6'h0C, v); chk("R5 ext idle without pulse", v, 32'd10);
    @(negedge clk); ext_tick = 1'b1;
    edges(3); ext_tick = 1'b0;
    rd(0, 6'h0C, v); chk("R5 ext counts", v, 32'd7);
    rd(1, 6'h0C, v); chk("R5 ext absent no count", v, 32'd10);
    wr(0, 6'h04, 32'h0); wr(1, 6'h04, 32'h0);
  endtask

  task automatic t_min;
    logic [31:0] v;
    wr(1, 6'h00, 32'h1);
    rd(1, 6'h00, v); chk("R1 outctl absent", v, 32'h0);
    wr(1, 6'h20, 32'h77); wr(1, 6'h2C, 32'h99);
    rd(1, 6'h20, v); chk("R11 ch2 absent reload", v, 32'h0);
    rd(1, 6'h2C, v); chk("R9 capture absent", v, 32'h0);
    wr(1, 6'h04, 32'h4);
    rd(1, 6'h04, v); chk("R2 bit2 stored", v, 32'h4);
    edges(20);
    chk("R2 bit2 inert irq", {29'b0, irq_min}, 32'h0);
    rd(1, 6'h0C, v); chk("R2 bit2 ch0 still", v, 32'd10);
    rd(1, 6'h18, v); chk("R2 bit2 ch1 still", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    edges(1);
    t_reset();
    t_map();
    t_countdown();
    t_flag();
    t_hold_restart();
    t_rates();
    t_ext();
    t_min();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule